// File: doc/BRIEF.md
# Four-Tone Frequency-Keyed Square-Wave Demodulator

This block takes a one-bit square wave that carries 4-ary frequency-shift keying and turns it back into a serial bit stream. In each symbol, the transmitter sends the inverted value of one bit of a free-running 4-bit divider. The least significant divider bit gives the fastest tone and the most significant bit gives the slowest. A symbol lasts one full divider cycle of 16 clocks. The receiver's window counter starts on the same clock as the transmitter's divider, so symbol boundaries line up and no timing recovery is needed.

In every window the block counts how often the input changes level. It compares that count with the count each tone would produce and picks the closest tone. It then sends the two-bit code of that tone out serially, most significant bit first. Each bit occupies half a window, and a one-clock strobe marks the first clock of each bit. When the `run` input is low, the whole block is held cleared. This input acts as the block's synchronous active-high-operate start/clear.

Top module: `fsk4_demod`

## Requirements
- R1: While `run` is low at a clock edge, the window position, the transition count and the first-window flag are cleared, and `bit_out` and `bit_valid` are 0 after that edge.
- R2: A window is 16 consecutive clocks. The first window starts at the first edge where `run` is high, and windows follow one another without gaps for as long as `run` stays high.
- R3: In each window the block counts changes of `tone_in` between consecutive samples. This gives 16 comparisons per window. The first comparison is against the last sample of the previous window, or against 0 right after a clear.
- R4: The tone for code 11 is the inverted divider bit 0 (16 changes per window). Code 10 uses bit 1 (8 changes), code 01 uses bit 2 (4 changes) and code 00 uses bit 3 (2 changes).
- R5: The decided code is the one whose nominal change count is nearest to the measured count. When two codes are equally near, the lower code wins. For example, 3 gives 00, 6 gives 01, 12 gives 10 and 0 gives 00.
- R6: The decision from the first window after `run` rises is dropped. `bit_valid` stays 0 and `bit_out` stays 0 until the second window's decision is output.
- R7: The MSB of a window's code appears on `bit_out` after the edge that samples the window's last clock, and it holds for 8 clocks. The LSB follows and also holds for 8 clocks.
- R8: `bit_valid` is high for exactly one clock when each new bit appears, and is low on every other clock.
- R9: A stream of random symbols keyed onto the input is recovered bit for bit, with the fixed latency given in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| run | input | 1 | High: operate. Low: hold everything cleared (synchronous) |
| tone_in | input | 1 | Keyed square-wave input |
| bit_out | output | 1 | Recovered serial data, MSB of each symbol first |
| bit_valid | output | 1 | One-clock strobe at the start of each recovered bit |

## Verification
The bench builds the block with its default divider width of 4. This gives 16-clock windows, four tones and two-bit codes, so every possible change count from 0 to 16 can be produced directly. Because of that, the bench can place the exact midpoints between tone counts in a window and test tie-breaking, as well as the ideal counts produced by a behavioural model of the keyed transmitter. With the same parameter values, a clear in the middle of a window lands at a known divider phase, which exposes how the first window after a restart is handled.

// File: rtl/fsk4_demod_pkg.sv
package fsk4_demod_pkg;

    // Per-clock window timing flags handed from the timer to the datapath
    typedef struct packed {
        logic open;      // first sample of a window
        logic close;     // last sample of a window
        logic slot_end;  // last sample of a serial bit slot
        logic primed;    // at least one window already completed
    } win_tick_t;

    // Level changes per window produced by the tone that encodes `code`
    function automatic int unsigned nominal_edges(input int unsigned code);
        return 32'd2 << code;
    endfunction

    function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/fsk4_window_timer.sv
module fsk4_window_timer
    import fsk4_demod_pkg::*;
#(
    parameter int unsigned DIV_BITS = 4,
    parameter int unsigned CODE_W   = 2
) (
    input  logic      clk,
    input  logic      run,
    output win_tick_t tick
);
    localparam int unsigned SLOT_BITS = DIV_BITS - $clog2(CODE_W);

    logic [DIV_BITS-1:0] pos_q;
    logic                primed_q;

    always_ff @(posedge clk) begin
        if (!run) begin
            pos_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            pos_q <= pos_q + 1'b1;
            if (pos_q == '1) primed_q <= 1'b1;
        end
    end

    always_comb begin
        tick.open     = run && (pos_q == '0);
        tick.close    = run && (pos_q == '1);
        tick.slot_end = run && (pos_q[SLOT_BITS-1:0] == '1);
        tick.primed   = primed_q;
    end

    // A closing sample is followed by an opening one while running
    assert_window_wrap_R2: assert property (@(posedge clk) disable iff (!run)
        tick.close |=> (!run || tick.open));

    // Once a window has closed, later decisions are eligible for output
    assert_primed_after_close_R6: assert property (@(posedge clk) disable iff (!run)
        tick.close |=> (!run || tick.primed));

endmodule

// File: rtl/fsk4_edge_counter.sv
module fsk4_edge_counter #(
    parameter int unsigned DIV_BITS = 4,
    localparam int unsigned CNT_W   = DIV_BITS + 1
) (
    input  logic             clk,
    input  logic             run,
    input  logic             tone_in,
    input  logic             open,
    output logic [CNT_W-1:0] total
);
    localparam int unsigned WIN = 1 << DIV_BITS;

    logic             prev_q;
    logic [CNT_W-1:0] acc_q;
    logic             flip;

    assign flip = tone_in ^ prev_q;

    always_comb total = (open ? '0 : acc_q) + CNT_W'(flip);

    always_ff @(posedge clk) begin
        if (!run) begin
            prev_q <= 1'b0;
            acc_q  <= '0;
        end else begin
            prev_q <= tone_in;
            acc_q  <= total;
        end
    end

    // A window holds at most one change per sample
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!run)
        total <= CNT_W'(WIN));

endmodule

// File: rtl/fsk4_tone_picker.sv
module fsk4_tone_picker
    import fsk4_demod_pkg::*;
#(
    parameter int unsigned DIV_BITS = 4,
    localparam int unsigned CNT_W   = DIV_BITS + 1,
    localparam int unsigned CODE_W  = $clog2(DIV_BITS)
) (
    input  logic              clk,
    input  logic              run,
    input  logic [CNT_W-1:0]  total,
    output logic [CODE_W-1:0] code
);
    localparam int unsigned TONES = DIV_BITS;

    int unsigned gaps [TONES];

    for (genvar c = 0; c < TONES; c++) begin : g_gap
        assign gaps[c] = abs_gap(int'(total), nominal_edges(c));
    end

    always_comb begin
        int unsigned best;
        best = 0;
        for (int unsigned c = 1; c < TONES; c++) begin
            if (gaps[c] < gaps[best]) best = c;
        end
        code = CODE_W'(best);
    end

    // No code is nearer, and no lower code is equally near
    always @(posedge clk) begin
        if (run) begin
            for (int unsigned c = 0; c < TONES; c++) begin
                assert_nearest_R5: assert ((c < int'(code)) ? (gaps[c] > gaps[code])
                                                            : (gaps[c] >= gaps[code]));
            end
        end
    end

endmodule

// File: rtl/fsk4_bit_serializer.sv
module fsk4_bit_serializer #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              run,
    input  logic              close,
    input  logic              slot_end,
    input  logic              primed,
    input  logic [CODE_W-1:0] code,
    output logic              bit_out,
    output logic              bit_valid
);
    logic [CODE_W-1:0] sh_q;
    logic              live_q;

    always_ff @(posedge clk) begin
        if (!run) begin
            sh_q      <= '0;
            live_q    <= 1'b0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            if (close) begin
                if (primed) begin
                    bit_out   <= code[CODE_W-1];
                    sh_q      <= code << 1;
                    live_q    <= 1'b1;
                    bit_valid <= 1'b1;
                end
            end else if (slot_end && live_q) begin
                bit_out   <= sh_q[CODE_W-1];
                sh_q      <= sh_q << 1;
                bit_valid <= 1'b1;
            end
        end
    end

    // Strobe lasts one clock
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!run)
        bit_valid |=> !bit_valid);

    // Strobe only follows a slot boundary from the timer
    assert_valid_on_slot_R8: assert property (@(posedge clk) disable iff (!run)
        bit_valid |-> $past(slot_end));

    // Data changes only together with the strobe
    assert_hold_R7: assert property (@(posedge clk) disable iff (!run)
        ($past(run) && !bit_valid) |-> $stable(bit_out));

endmodule

// File: rtl/fsk4_demod.sv
module fsk4_demod
    import fsk4_demod_pkg::*;
#(
    parameter int unsigned DIV_BITS = 4
) (
    input  logic clk,
    input  logic run,
    input  logic tone_in,
    output logic bit_out,
    output logic bit_valid
);
    localparam int unsigned CODE_W = $clog2(DIV_BITS);
    localparam int unsigned CNT_W  = DIV_BITS + 1;

    win_tick_t         tick;
    logic [CNT_W-1:0]  total;
    logic [CODE_W-1:0] code;

    fsk4_window_timer #(.DIV_BITS(DIV_BITS), .CODE_W(CODE_W)) u_timer (
        .clk  (clk),
        .run  (run),
        .tick (tick)
    );

    fsk4_edge_counter #(.DIV_BITS(DIV_BITS)) u_count (
        .clk     (clk),
        .run     (run),
        .tone_in (tone_in),
        .open    (tick.open),
        .total   (total)
    );

    fsk4_tone_picker #(.DIV_BITS(DIV_BITS)) u_pick (
        .clk   (clk),
        .run   (run),
        .total (total),
        .code  (code)
    );

    fsk4_bit_serializer #(.CODE_W(CODE_W)) u_ser (
        .clk       (clk),
        .run       (run),
        .close     (tick.close),
        .slot_end  (tick.slot_end),
        .primed    (tick.primed),
        .code      (code),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    // Nothing is emitted before the first window has been discarded
    assert_quiet_first_R6: assert property (@(posedge clk) disable iff (!run)
        !tick.primed |-> !bit_valid);

endmodule

// File: tb/test_fsk4_demod.sv
`timescale 1ns/1ps
module test_fsk4_demod;
    logic clk = 1'b0;
    logic run = 1'b0;
    logic tone_in = 1'b0;
    logic bit_out, bit_valid;

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] pend_code = 2'b00;
    bit pend_live = 1'b0;
    bit first_win = 1'b1;
    bit level = 1'b0;

    always #4 clk = ~clk;

    fsk4_demod i_fsk4_demod (
        .clk(clk), .run(run), .tone_in(tone_in),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gap(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // R5 reference: nearest nominal count, ties toward lower code; code c -> 2<<c changes
    function automatic logic [1:0] pick_code(input int cnt);
        int best = 0;
        for (int c = 1; c < 4; c++)
            if (gap(cnt, 2 << c) < gap(cnt, 2 << best)) best = c;
        return 2'(best);
    endfunction

    // R4 transmitter model: code s keys inverted divider bit (3 - s)
    function automatic logic [15:0] tone_pattern(input int sym);
        logic [15:0] p;
        for (int k = 0; k < 16; k++) p[k] = ~((k >> (3 - sym)) & 1);
        return p;
    endfunction

    function automatic logic [15:0] edge_pattern(input int n, input bit start_lv);
        logic [15:0] p;
        bit lv = start_lv;
        for (int k = 0; k < 16; k++) begin
            if (k < n) lv = ~lv;
            p[k] = lv;
        end
        return p;
    endfunction

    // Drives one 16-sample window and checks the outputs that belong to the previous one
    task automatic send_window(input logic [15:0] pat, input string tag);
        bit lv = level;
        int edges = 0;
        bit quiet_ok = 1'b1, hold_ok = 1'b1, zero_ok = 1'b1;
        logic v0 = 1'b0, v8 = 1'b0, b0 = 1'b0, b8 = 1'b0;
        for (int k = 0; k < 16; k++) begin
            edges += (pat[k] != lv);
            lv = pat[k];
        end
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (bit_out !== 1'b0) zero_ok = 1'b0;
            if (k == 0) begin v0 = bit_valid; b0 = bit_out; end
            else if (k == 8) begin v8 = bit_valid; b8 = bit_out; end
            else begin
                if (bit_valid !== 1'b0) quiet_ok = 1'b0;
                if (k < 8 && bit_out !== b0) hold_ok = 1'b0;
                if (k > 8 && bit_out !== b8) hold_ok = 1'b0;
            end
            run = 1'b1;
            tone_in = pat[k];
        end
        if (pend_live) begin
            check(v0 === 1'b1 && b0 === pend_code[1], {tag, " R7 MSB of symbol"},
                  {v0, b0}, {1'b1, pend_code[1]});
            check(v8 === 1'b1 && b8 === pend_code[0], {tag, " R7 LSB of symbol"},
                  {v8, b8}, {1'b1, pend_code[0]});
            check(quiet_ok && hold_ok, {tag, " R8 single strobe and held data"},
                  {quiet_ok, hold_ok}, 3);
        end else begin
            check(v0 === 1'b0 && v8 === 1'b0 && quiet_ok && zero_ok,
                  {tag, " R6 no output from first window"}, {v0, v8, zero_ok}, 1);
        end
        pend_code = pick_code(edges);
        pend_live = !first_win;
        first_win = 1'b0;
        level = pat[15];
    endtask

    task automatic restart();
        @(negedge clk);
        run = 1'b0;
        tone_in = 1'b0;
        @(negedge clk);
        check(bit_out === 1'b0 && bit_valid === 1'b0, "R1 cleared while run low",
              {bit_out, bit_valid}, 0);
        level = 1'b0;
        pend_live = 1'b0;
        first_win = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(bit_out === 1'b0 && bit_valid === 1'b0, "R1 reset state",
              {bit_out, bit_valid}, 0);
    endtask

    task automatic t_tones();
        restart();
        for (int s = 0; s < 4; s++) send_window(tone_pattern(s), "R4 R2 fixed tone");
        for (int i = 0; i < 40; i++) send_window(tone_pattern($urandom_range(0, 3)), "R9 random");
        send_window(tone_pattern(0), "R9 flush");
    endtask

    task automatic t_ties();
        int counts [12] = '{3, 6, 12, 0, 1, 5, 10, 14, 15, 16, 2, 7};
        restart();
        send_window(edge_pattern(2, level), "R3 lead");
        foreach (counts[i]) send_window(edge_pattern(counts[i], level), "R5 R3 count");
        send_window(edge_pattern(4, level), "R5 flush");
    endtask

    task automatic t_midclear();
        restart();
        for (int i = 0; i < 3; i++) send_window(tone_pattern(3 - i), "R7 pre-clear");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            tone_in = ~tone_in;
        end
        restart();
        send_window(tone_pattern(1), "R6 after clear");
        send_window(tone_pattern(2), "R6 second window");
        send_window(tone_pattern(3), "R1 restart decode");
        send_window(tone_pattern(0), "R1 flush");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_tones();
        t_ties();
        t_midclear();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule